// File: doc/BRIEF.md
# Line-change timestamp engine

This block watches a bank of input lines for changes of level and stamps each change with the value of a free-running 64-bit system counter. The lines are grouped into 32-bit slices, and the slice count is a build parameter. Every line has a flat numeric identifier equal to `32*slice + bit`. Software turns each line on or off for stamping through one enable word per slice. Each stamp becomes a record holding the counter value, the line identifier and the line's new level. Records are queued in an internal FIFO that software drains through a small word-addressed register port.

Inputs pass through a two-flop synchroniser. All enabled lines that differ from their last reported level are captured together as one group, stamped with one counter value. The group is then written into the FIFO one record per cycle, lowest identifier first.

The path from the group register to the FIFO is a valid/ready stream. Changes on the monitored lines cannot be held back, so when the FIFO is not ready a record is discarded and a sticky overflow flag is set. It is never stalled. An interrupt output is high whenever the FIFO occupancy is at or above a programmable threshold.

Register map (word addresses on `reg_addr`):

| Address | Access | Content |
|---|---|---|
| 0x00 | read, write 1 to clear | status word |
| 0x01 | read/write | threshold |
| 0x02 | read, no side effect | low word of the head record's counter value |
| 0x03 | read, no side effect | high word of the head record's counter value |
| 0x04 | read, pops when a record is present | head record's line, level and valid flag |
| 0x20 + s | read/write | enable word of slice s |

Top module: `line_ts_engine`

## Requirements
- R1: After reset the FIFO is empty, every enable word reads 0, the threshold reads 1, the overflow flag is 0 and `irq` is low. The status word at address 0x00 reads 0x0000_0004. Its fields are: bit 0 overflow, bit 1 interrupt, bit 2 FIFO empty, bits 31:16 occupancy.
- R2: The enable word of slice s is at address 0x20+s, and its bit b enables line 32*s+b. Each enable word reads back what was written. An address 0x20+s with s at or beyond the slice count reads 0.
- R3: When an enabled line changes level while the engine is idle, one record is produced. It carries the line's identifier and new level. Its timestamp is the counter value present two cycles after the cycle in which the line changed, that is, the value seen at the third rising edge.
- R4: A change on a disabled line produces no record. Enabling a line whose level is steady produces no record.
- R5: Enabled lines that change in the same cycle produce one record each, written one per cycle in ascending identifier order. All of these records carry the same timestamp.
- R6: Address 0x02 returns the low 32 bits of the head timestamp and 0x03 the high 32 bits; these reads have no side effect. Address 0x04 returns bit 31 valid, bit 16 level and bits 15:0 line identifier, and reading it pops the record. Reading 0x04 with the FIFO empty returns 0 and changes nothing.
- R7: Writing the threshold stores the value, with two exceptions: writing 0 stores 1, and writing a value above 256 stores 256.
- R8: `irq` is high exactly while the occupancy is greater than or equal to the threshold. It falls in the cycle after the read that brings the occupancy below the threshold.
- R9: A record arriving while the FIFO is full is discarded and sets the overflow flag, which stays set. Writing 1 to status bit 0 clears the flag, and writing 0 leaves it unchanged.
- R10: Records leave the FIFO in the order they were written, across groups. The FIFO holds up to FIFO_DEPTH records.
- R11: Enabled lines that change while an earlier group is still being written wait until that group is fully written. They then form the next group, stamped with the counter value at the cycle that group is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| lines_in | input | NUM_SLICES*32 | monitored lines, asynchronous to clk |
| sys_count | input | 64 | free-running system counter, already in the clk domain |
| reg_addr | input | 8 | register word address |
| reg_wr | input | 1 | write strobe, one cycle per write |
| reg_wdata | input | 32 | write data |
| reg_rd | input | 1 | read strobe; a read of 0x04 pops on the rising edge |
| reg_rdata | output | 32 | read data, valid in the cycle of `reg_addr` |
| irq | output | 1 | high while occupancy is at or above the threshold |

## Verification
The bench applies four stimulus shapes, each aimed at a different failure:
- Single toggles on enabled lines, in both directions, pin down the three-edge timestamp latency and the level bit.
- Toggles on disabled lines, and enabling a steady line, separate real changes from spurious ones.
- Bursts of several lines in one cycle, including one burst larger than the FIFO, expose any fault in the ordering, the shared timestamp and the drop-and-flag behaviour on a full FIFO.
- A change arriving one cycle after a burst tells whether the engine defers it to a fresh group with a later stamp.

Random enable masks with random one- and two-line toggles from a fixed seed then mix all of these shapes.

// File: rtl/lcts_pkg.sv
package lcts_pkg;
  localparam int TS_W    = 64;
  localparam int ID_W    = 16;
  localparam int SLICE_W = 32;
  localparam int THR_MAX = 256;
  localparam int THR_W   = $clog2(THR_MAX + 1);

  typedef struct packed {
    logic [TS_W-1:0] ts;
    logic [ID_W-1:0] line;
    logic            level;
  } rec_t;

  localparam logic [7:0] A_STATUS  = 8'h00;
  localparam logic [7:0] A_THRESH  = 8'h01;
  localparam logic [7:0] A_TS_LO   = 8'h02;
  localparam logic [7:0] A_TS_HI   = 8'h03;
  localparam logic [7:0] A_INFO    = 8'h04;
  localparam logic [7:0] A_EN_BASE = 8'h20;
endpackage

// File: rtl/lcts_sync.sv
module lcts_sync #(
  parameter int W = 96
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/lcts_capture.sv
module lcts_capture
  import lcts_pkg::*;
#(
  parameter int NL = 96
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NL-1:0]   lvl,
  input  logic [NL-1:0]   en,
  input  logic [TS_W-1:0] ts_in,
  output logic            out_valid,
  input  logic            out_ready,
  output rec_t            out_rec,
  output logic            drop
);
  logic [NL-1:0]   rep_q;   // last reported level per line
  logic [NL-1:0]   batch_q; // lines of the current group still to write
  logic [NL-1:0]   blvl_q;  // levels captured with the group
  logic [TS_W-1:0] bts_q;   // timestamp of the group

  logic [NL-1:0] pend, take, grant;
  logic          load;
  logic [ID_W-1:0] gidx;

  assign pend  = en & (lvl ^ rep_q);
  assign load  = (batch_q == '0) && (pend != '0);
  assign take  = ~en | (load ? pend : '0);
  assign grant = batch_q & (-batch_q);

  always_comb begin
    gidx = '0;
    for (int i = 0; i < NL; i++) begin
      if (grant[i]) gidx = ID_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_q   <= '0;
      batch_q <= '0;
      blvl_q  <= '0;
      bts_q   <= '0;
    end else begin
      rep_q <= (rep_q & ~take) | (lvl & take);
      if (load) begin
        batch_q <= pend;
        blvl_q  <= lvl;
        bts_q   <= ts_in;
      end else begin
        batch_q <= batch_q & ~grant;
      end
    end
  end

  assign out_valid     = (batch_q != '0);
  assign drop          = out_valid && !out_ready;
  assign out_rec.ts    = bts_q;
  assign out_rec.line  = gidx;
  assign out_rec.level = |(blvl_q & grant);

  // R5
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R11
  batch_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (batch_q != '0) |=> ((batch_q & ~$past(batch_q)) == '0));
  // R5
  batch_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (batch_q != '0) |=> ($countones(batch_q) == $countones($past(batch_q)) - 1));
endmodule

// File: rtl/lcts_fifo.sv
module lcts_fifo
  import lcts_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  rec_t                       in_rec,
  output logic                       out_valid,
  input  logic                       pop,
  output rec_t                       out_rec,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  rec_t          mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          wr_en, rd_en;

  assign in_ready  = (count != CW'(DEPTH));
  assign out_valid = (count != '0);
  assign wr_en     = in_valid && in_ready;
  assign rd_en     = pop && out_valid;
  assign out_rec   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= in_rec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + AW'(1);
      if (rd_en) rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + AW'(1);
      case ({wr_en, rd_en})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R10
  count_le_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R6
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && count == '0 && !in_valid) |=> (count == '0));
endmodule

// File: rtl/line_ts_engine.sv
module line_ts_engine
  import lcts_pkg::*;
#(
  parameter int NUM_SLICES = 3,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SLICES*SLICE_W-1:0] lines_in,
  input  logic [TS_W-1:0]               sys_count,
  input  logic [7:0]                    reg_addr,
  input  logic                          reg_wr,
  input  logic [31:0]                   reg_wdata,
  input  logic                          reg_rd,
  output logic [31:0]                   reg_rdata,
  output logic                          irq
);
  localparam int NL = NUM_SLICES * SLICE_W;
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic [NL-1:0]    lvl, en_q;
  logic [THR_W-1:0] thr_q;
  logic             ovf_q;
  logic             cap_valid, cap_ready, drop, head_valid, pop;
  rec_t             cap_rec, head_rec;
  logic [CW-1:0]    fifo_count;

  lcts_sync #(.W(NL)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(lines_in), .q(lvl)
  );

  lcts_capture #(.NL(NL)) u_capture (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .en(en_q), .ts_in(sys_count),
    .out_valid(cap_valid), .out_ready(cap_ready), .out_rec(cap_rec), .drop(drop)
  );

  lcts_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(cap_valid), .in_ready(cap_ready),
    .in_rec(cap_rec), .out_valid(head_valid), .pop(pop), .out_rec(head_rec),
    .count(fifo_count)
  );

  assign pop = reg_rd && (reg_addr == A_INFO) && head_valid;
  assign irq = (32'(fifo_count) >= 32'(thr_q));

  // enable bitmap, one word per slice
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (reg_wr) begin
      for (int s = 0; s < NUM_SLICES; s++) begin
        if (reg_addr == A_EN_BASE + 8'(s)) en_q[s*SLICE_W +: SLICE_W] <= reg_wdata;
      end
    end
  end

  // threshold with clamping to 1..THR_MAX
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= THR_W'(1);
    end else if (reg_wr && reg_addr == A_THRESH) begin
      if (reg_wdata == 32'd0)                 thr_q <= THR_W'(1);
      else if (reg_wdata > 32'(THR_MAX))      thr_q <= THR_W'(THR_MAX);
      else                                    thr_q <= reg_wdata[THR_W-1:0];
    end
  end

  // sticky overflow, set wins over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                                 ovf_q <= 1'b0;
    else if (drop)                                              ovf_q <= 1'b1;
    else if (reg_wr && reg_addr == A_STATUS && reg_wdata[0])    ovf_q <= 1'b0;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STATUS: begin
        reg_rdata[0]     = ovf_q;
        reg_rdata[1]     = irq;
        reg_rdata[2]     = !head_valid;
        reg_rdata[31:16] = 16'(fifo_count);
      end
      A_THRESH: reg_rdata = 32'(thr_q);
      A_TS_LO:  reg_rdata = head_valid ? head_rec.ts[31:0]  : 32'd0;
      A_TS_HI:  reg_rdata = head_valid ? head_rec.ts[63:32] : 32'd0;
      A_INFO: begin
        if (head_valid) begin
          reg_rdata[31]   = 1'b1;
          reg_rdata[16]   = head_rec.level;
          reg_rdata[15:0] = head_rec.line;
        end
      end
      default: begin
        for (int s = 0; s < NUM_SLICES; s++) begin
          if (reg_addr == A_EN_BASE + 8'(s)) reg_rdata = en_q[s*SLICE_W +: SLICE_W];
        end
      end
    endcase
  end

  // R7
  thresh_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_q >= THR_W'(1)) && (32'(thr_q) <= 32'(THR_MAX)));
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf_q);
  // R8
  irq_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == '0) |-> !irq);
endmodule

// File: tb/line_ts_engine_bench.sv
module line_ts_engine_bench;
  localparam int NS = 3;
  localparam int NL = NS * 32;
  localparam int DEPTH = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] lines = '0;
  logic [63:0]   sys_count;
  logic [7:0]    reg_addr = '0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq;
  logic [NL-1:0] en_model = '0;
  int checks = 0, fails = 0;

  line_ts_engine #(.NUM_SLICES(NS), .FIFO_DEPTH(DEPTH)) u_line_ts_engine (
    .clk(clk), .rst_n(rst_n), .lines_in(lines), .sys_count(sys_count),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sys_count <= '0;
    else        sys_count <= sys_count + 64'd1;
  end

  function automatic logic [63:0] exp_ts(input logic [63:0] c);
    return c + 64'd2;
  endfunction

  function automatic logic [31:0] exp_info(input int id, input logic lv);
    return {1'b1, 14'd0, lv, 16'(id)};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic toggle(input logic [NL-1:0] m, output logic [63:0] c);
    @(negedge clk); lines = lines ^ m; c = sys_count;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_rec(input string req, input int id, input logic [63:0] ets);
    logic [31:0] lo, hi, info;
    rd(8'h02, lo); rd(8'h03, hi); rd(8'h04, info);
    chk(req, info, exp_info(id, lines[id]), "record info");
    chk(req, {hi, lo}, ets, "record timestamp");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic [63:0] c, c2;
    logic [NL-1:0] m;
    int unsigned seed;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(8'h00, d); chk("R1", d, 32'h0000_0004, "status after reset");
    rd(8'h01, d); chk("R1", d, 32'd1, "threshold after reset");
    rd(8'h20, d); chk("R1", d, 32'd0, "enable word after reset");
    chk("R1", irq, 1'b0, "irq after reset");

    // R4 disabled line toggles
    toggle(NL'(1) << 3, c); idle(6);
    rd(8'h00, d); chk("R4", d, 32'h0000_0004, "no record from disabled line");

    // R2 enable words
    wr(8'h21, 32'hA5A5_0001); rd(8'h21, d); chk("R2", d, 32'hA5A5_0001, "slice 1 readback");
    wr(8'h22, 32'hFFFF_FFFF); rd(8'h22, d); chk("R2", d, 32'hFFFF_FFFF, "last slice readback");
    wr(8'h23, 32'h1234_5678); rd(8'h23, d); chk("R2", d, 32'd0, "unmapped slice reads 0");
    for (int s = 0; s < NS; s++) wr(8'h20 + 8'(s), 32'hFFFF_FFFF);
    en_model = '1;
    idle(6);
    rd(8'h00, d); chk("R4", d, 32'h0000_0004, "enabling a steady line adds nothing");

    // R3 single changes, both directions
    toggle(NL'(1) << 40, c); idle(6);
    expect_rec("R3", 40, exp_ts(c));
    toggle(NL'(1) << 40, c); idle(6);
    expect_rec("R3", 40, exp_ts(c));

    // R6 read of empty FIFO
    rd(8'h04, d); chk("R6", d, 32'd0, "info read when empty");
    rd(8'h00, d); chk("R6", d, 32'h0000_0004, "status after empty info read");

    // R5 simultaneous changes
    m = (NL'(1) << 70) | (NL'(1) << 5) | (NL'(1) << 64);
    toggle(m, c); idle(8);
    expect_rec("R5", 5, exp_ts(c));
    expect_rec("R5", 64, exp_ts(c));
    expect_rec("R5", 70, exp_ts(c));

    // R11 change during drain forms a later group
    toggle((NL'(1) << 10) | (NL'(1) << 11), c);
    toggle(NL'(1) << 12, c2);
    idle(10);
    expect_rec("R11", 10, exp_ts(c));
    expect_rec("R11", 11, exp_ts(c));
    expect_rec("R11", 12, c + 64'd5);

    // R7 threshold clamping
    wr(8'h01, 32'd0);   rd(8'h01, d); chk("R7", d, 32'd1, "threshold 0 clamps to 1");
    wr(8'h01, 32'd300); rd(8'h01, d); chk("R7", d, 32'd256, "threshold above 256 clamps");
    wr(8'h01, 32'd256); rd(8'h01, d); chk("R7", d, 32'd256, "threshold 256 kept");
    wr(8'h01, 32'd3);   rd(8'h01, d); chk("R7", d, 32'd3, "threshold 3 kept");

    // R8 interrupt at threshold 3
    toggle(NL'(1) << 20, c); idle(6); chk("R8", irq, 1'b0, "irq at 1 of 3");
    toggle(NL'(1) << 21, c); idle(6); chk("R8", irq, 1'b0, "irq at 2 of 3");
    toggle(NL'(1) << 22, c); idle(6); chk("R8", irq, 1'b1, "irq at 3 of 3");
    rd(8'h00, d); chk("R8", d, 32'h0003_0002, "status at threshold");
    rd(8'h04, d); chk("R8", d, exp_info(20, lines[20]), "pop first");
    chk("R8", irq, 1'b0, "irq after pop below threshold");
    rd(8'h04, d); rd(8'h04, d);
    rd(8'h00, d); chk("R10", d, 32'h0000_0004, "drained");

    // R9 overflow: 18 lines into a 16-deep FIFO
    m = '0;
    for (int i = 30; i < 48; i++) m[i] = 1'b1;
    toggle(m, c); idle(25);
    rd(8'h00, d); chk("R9", d, 32'h0010_0003, "full with overflow");
    wr(8'h00, 32'd0); rd(8'h00, d); chk("R9", d, 32'h0010_0003, "write 0 keeps overflow");
    wr(8'h00, 32'd1); rd(8'h00, d); chk("R9", d, 32'h0010_0002, "write 1 clears overflow");
    for (int i = 30; i < 46; i++) expect_rec("R10", i, exp_ts(c));
    rd(8'h00, d); chk("R9", d, 32'h0000_0004, "dropped records absent");
    chk("R8", irq, 1'b0, "irq low when empty");

    // R10 random enables and toggles
    seed = $urandom(32'd1234);
    for (int s = 0; s < NS; s++) begin
      d = $urandom();
      wr(8'h20 + 8'(s), d);
      en_model[s*32 +: 32] = d;
    end
    idle(6);
    rd(8'h00, d); chk("R4", d, 32'h0000_0004, "mask change adds nothing");
    for (int it = 0; it < 40; it++) begin
      int a, b, lo_id, hi_id;
      a = int'($urandom_range(NL-1, 0));
      b = int'($urandom_range(NL-1, 0));
      lo_id = (a < b) ? a : b;
      hi_id = (a < b) ? b : a;
      m = (NL'(1) << a) | (NL'(1) << b);
      toggle(m, c); idle(6);
      if (en_model[lo_id]) expect_rec("R10", lo_id, exp_ts(c));
      if (hi_id != lo_id && en_model[hi_id]) expect_rec("R5", hi_id, exp_ts(c));
      rd(8'h00, d); chk("R4", d, 32'h0000_0004, "only enabled lines recorded");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule